// File: doc/BRIEF.md
# Infrared serial pulse encoder

The block turns the bit stream a UART sends into the short light pulses that a serial infrared transmitter expects. It runs on one fast base clock. A single-cycle enable, `tick16`, marks sixteen equal slices of every bit time. A zero bit on the serial input becomes one high pulse on `ir_out`. The pulse is three slices wide and starts after seven low slices, so it sits near the middle of the bit. A one bit leaves the output low.

In the default shaping mode the encoder output goes straight to `ir_out`. When `fixed_mode` is high, a one-shot runs on the base clock. Each rising edge of the encoder output fires it, and it drives `ir_out` high for a fixed number of base-clock cycles. This number does not depend on how far apart the ticks are. `fixed_mode` is a static setting. Change it only while the line is idle, and use it only when `tick16` comes from the base clock by division.

The encoder is a four-state machine. IDLE waits for a falling edge. LEAD counts the low slices before the pulse. PULSE holds the output high. TRAIL runs to the end of the bit. Its transitions are:
- start: IDLE to LEAD, on a tick that samples the input low after a high sample.
- fire: LEAD to PULSE, on slice 7.
- drop: PULSE to TRAIL, on slice 10.
- chain: TRAIL to LEAD, on the next bit boundary if the input is still low.
- rest: TRAIL to IDLE, on that boundary if the input is high.

The one-shot has two states, QUIET and HIGH. The transition load takes QUIET to HIGH on a rising edge. reload stays in HIGH and restarts the count on a new edge. expire takes HIGH back to QUIET when the count runs out.

Top module: `irsir_tx`

## Requirements
- R1: A tick that samples `txd_ser` low, after the tick before it sampled it high, is slice 0 of a zero bit. In shaping mode `ir_out` stays low for the 7 tick periods after slice 0 and rises just after the tick of slice 7.
- R2: In shaping mode each pulse stays high for exactly 3 tick periods. It falls just after the tick of slice 10.
- R3: If `txd_ser` is still low at the tick of slice 16, that tick is slice 0 of a new zero bit. A run of zero bits therefore gives one pulse per bit, with rises 16 ticks apart.
- R4: A one bit gives no pulse. `ir_out` stays low through every bit that is sampled high at its boundary.
- R5: With `fixed_mode` high, each encoder pulse gives one `ir_out` pulse. That pulse rises one base clock after the encoder output rises and lasts exactly 6 base clocks, whatever the tick spacing.
- R6: While `rst_n` is low, `ir_out` is low and both machines return to their idle states. This holds even if reset lands in the middle of a pulse. After release, a line that is held high produces no pulse.
- R7: Once a zero bit has started, it runs to slice 16 even if `txd_ser` rises partway through. Only the level sampled at the boundary decides whether a further zero bit follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable, sixteen per bit time |
| txd_ser | input | 1 | Serial data from the UART, idle high |
| fixed_mode | input | 1 | High selects fixed-width pulses of base-clock length |
| ir_out | output | 1 | Infrared transmit pulse, active high |

## Verification
Two events can fall on the same tick: the end of one zero bit, and either the start of the next zero bit or the decision to go idle. The bench provokes this with an all-zero byte, and with zero bits that alternate with ones. Each scoreboarded rise must land exactly 16 ticks after the one before it, or no rise may appear at all. A second collision is a mid-bit rise or fall of the serial input while a frame is running. The bench judges it by the number and position of pulses it sees. In fixed-width mode the pulse widths are measured in base clocks at two tick spacings.

// File: rtl/irsir_pkg.sv
`timescale 1ns/1ps
package irsir_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_LEAD,
        FR_PULSE,
        FR_TRAIL
    } frame_state_e;

    typedef enum logic {
        SH_QUIET,
        SH_HIGH
    } shot_state_e;

endpackage

// File: rtl/irsir_frame_fsm.sv
`timescale 1ns/1ps
module irsir_frame_fsm
    import irsir_pkg::*;
#(
    parameter int BIT_TICKS   = 16,
    parameter int LEAD_TICKS  = 7,
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ser_in,
    output logic mod_out
);

    localparam int CNT_W = $clog2(BIT_TICKS);
    localparam logic [CNT_W-1:0] SLICE_FIRE = CNT_W'(LEAD_TICKS);
    localparam logic [CNT_W-1:0] SLICE_DROP = CNT_W'(LEAD_TICKS + PULSE_TICKS);
    localparam logic [CNT_W-1:0] SLICE_LAST = CNT_W'(BIT_TICKS - 1);
    localparam logic [CNT_W-1:0] SLICE_ONE  = CNT_W'(1);

    frame_state_e     state, state_n;
    logic [CNT_W-1:0] slice, slice_n;
    logic             ser_last;
    logic             mod_q;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v == SLICE_LAST) ? '0 : v + SLICE_ONE;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= FR_IDLE;
            slice    <= '0;
            ser_last <= 1'b1;
        end else begin
            state <= state_n;
            slice <= slice_n;
            if (tick) ser_last <= ser_in;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        slice_n = slice;
        if (tick) begin
            unique case (state)
                FR_IDLE: begin
                    if (ser_last && !ser_in) begin
                        state_n = FR_LEAD;
                        slice_n = SLICE_ONE;
                    end
                end
                FR_LEAD: begin
                    slice_n = bump(slice);
                    if (slice == SLICE_FIRE) state_n = FR_PULSE;
                end
                FR_PULSE: begin
                    slice_n = bump(slice);
                    if (slice == SLICE_DROP) state_n = FR_TRAIL;
                end
                FR_TRAIL: begin
                    if (slice == '0) begin
                        if (!ser_in) begin
                            state_n = FR_LEAD;
                            slice_n = SLICE_ONE;
                        end else begin
                            state_n = FR_IDLE;
                            slice_n = '0;
                        end
                    end else begin
                        slice_n = bump(slice);
                    end
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mod_q <= 1'b0;
        else        mod_q <= (state_n == FR_PULSE);
    end

    assign mod_out = mod_q;

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(mod_out)); // R1
    AST_DROP_INTO_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_out) |-> (state == FR_TRAIL || state == FR_IDLE)); // R2
    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE) |-> !mod_out); // R4
    AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == FR_LEAD && ser_in) |=> (state != FR_IDLE)); // R7

endmodule

// File: rtl/irsir_oneshot.sv
`timescale 1ns/1ps
module irsir_oneshot
    import irsir_pkg::*;
#(
    parameter int SHOT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig_in,
    output logic shot_out
);

    localparam int SW = $clog2(SHOT_CYCLES + 1);
    localparam logic [SW-1:0] SHOT_LOAD = SW'(SHOT_CYCLES);
    localparam logic [SW-1:0] SHOT_ONE  = SW'(1);

    shot_state_e   state, state_n;
    logic [SW-1:0] left, left_n;
    logic          trig_last;
    logic          shot_q;
    logic          fire;

    assign fire = enable && trig_in && !trig_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= SH_QUIET;
            left      <= '0;
            trig_last <= 1'b0;
        end else begin
            state     <= state_n;
            left      <= left_n;
            trig_last <= trig_in;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        left_n  = left;
        unique case (state)
            SH_QUIET: begin
                if (fire) begin
                    state_n = SH_HIGH;
                    left_n  = SHOT_LOAD;
                end
            end
            SH_HIGH: begin
                if (fire) begin
                    left_n = SHOT_LOAD;
                end else if (left == SHOT_ONE) begin
                    state_n = SH_QUIET;
                    left_n  = '0;
                end else begin
                    left_n = left - SHOT_ONE;
                end
            end
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shot_q <= 1'b0;
        else        shot_q <= (state_n == SH_HIGH);
    end

    assign shot_out = shot_q;

    AST_SHOT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (left == SHOT_LOAD && shot_out)); // R5
    AST_SHOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        left <= SHOT_LOAD); // R5
    AST_SHOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shot_out) |-> ($past(left) == SHOT_ONE)); // R5

endmodule

// File: rtl/irsir_tx.sv
`timescale 1ns/1ps
module irsir_tx #(
    parameter int BIT_TICKS   = 16,
    parameter int LEAD_TICKS  = 7,
    parameter int PULSE_TICKS = 3,
    parameter int SHOT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic txd_ser,
    input  logic fixed_mode,
    output logic ir_out
);

    logic mod_pulse;
    logic shot_pulse;

    irsir_frame_fsm #(
        .BIT_TICKS  (BIT_TICKS),
        .LEAD_TICKS (LEAD_TICKS),
        .PULSE_TICKS(PULSE_TICKS)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .ser_in (txd_ser),
        .mod_out(mod_pulse)
    );

    irsir_oneshot #(
        .SHOT_CYCLES(SHOT_CYCLES)
    ) u_shot (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (fixed_mode),
        .trig_in (mod_pulse),
        .shot_out(shot_pulse)
    );

    assign ir_out = fixed_mode ? shot_pulse : mod_pulse;

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> !ir_out); // R6
    AST_SHOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_mode && $rose(mod_pulse)) |=> ir_out); // R5

endmodule

// File: tb/tb_irsir_tx.sv
`timescale 1ns/1ps
module tb_irsir_tx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic txd_ser = 1'b1;
    logic fixed_mode = 1'b0;
    logic ir_out;

    always #2 clk = ~clk;

    irsir_tx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .txd_ser   (txd_ser),
        .fixed_mode(fixed_mode),
        .ir_out    (ir_out)
    );

    int checks = 0;
    int errors = 0;
    int div = 1;
    int div_cnt = 0;
    int tick_num = 0;
    bit mon_en = 1'b0;
    bit in_pulse = 1'b0;
    int rise_tick = 0;
    int hi_len = 0;
    string tag_pos = "R1";
    string tag_w = "R2";
    int exp_rise_q[$];
    int exp_w_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // tick generator and scoreboard monitor share the falling edge
    always @(negedge clk) begin
        if (!mon_en) begin
            in_pulse = 1'b0;
            hi_len = 0;
        end else if (ir_out) begin
            if (!in_pulse) begin
                in_pulse = 1'b1;
                rise_tick = tick_num;
                hi_len = 0;
            end
            hi_len++;
        end else if (in_pulse) begin
            in_pulse = 1'b0;
            if (exp_rise_q.size() == 0) begin
                check(1'b0, "R4 unexpected pulse", rise_tick, -1);
            end else begin
                int er;
                int ew;
                er = exp_rise_q.pop_front();
                ew = exp_w_q.pop_front();
                check(rise_tick == er, tag_pos, rise_tick, er);
                check(hi_len == ew, tag_w, hi_len, ew);
            end
        end
        if (div_cnt >= div - 1) begin
            div_cnt <= 0;
            tick16 <= 1'b1;
            tick_num <= tick_num + 1;
        end else begin
            div_cnt <= div_cnt + 1;
            tick16 <= 1'b0;
        end
    end

    task automatic wait_tick(output int t);
        @(posedge clk);
        while (!tick16) @(posedge clk);
        t = tick_num;
    endtask

    task automatic idle_ticks(input int n);
        int t;
        for (int i = 0; i < n; i++) wait_tick(t);
    endtask

    function automatic int pulse_len();
        return fixed_mode ? 6 : 3 * div;
    endfunction

    task automatic send_byte(input logic [7:0] d);
        logic [9:0] fr;
        int t0;
        int t;
        fr = {1'b1, d, 1'b0};
        wait_tick(t0);
        for (int j = 0; j < 10; j++) begin
            if (!fr[j]) begin
                exp_rise_q.push_back(t0 + 1 + 16 * j + 7);
                exp_w_q.push_back(pulse_len());
            end
            #1 txd_ser = fr[j];
            for (int k = 0; k < 16; k++) wait_tick(t);
        end
        idle_ticks(20);
    endtask

    task automatic expect_drained(input string tag);
        check(exp_rise_q.size() == 0, tag, exp_rise_q.size(), 0);
        exp_rise_q.delete();
        exp_w_q.delete();
    endtask

    initial begin
        int t0;
        int t;
        // reset state, R6
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ir_out == 1'b0, "R6 low in reset", ir_out, 0);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;
        idle_ticks(40);
        check(ir_out == 1'b0, "R6 quiet after release", ir_out, 0);
        expect_drained("R6 no pulse on idle line");

        // alternating zero bits, R1 R2
        div = 1;
        tag_pos = "R1 rise slice"; tag_w = "R2 width";
        send_byte(8'h55);
        expect_drained("R1 all pulses seen");

        // wider tick spacing, consecutive zeros, R3
        div = 4;
        idle_ticks(4);
        tag_pos = "R3 chained rise"; tag_w = "R2 width div4";
        send_byte(8'h00);
        expect_drained("R3 all pulses seen");

        // marks only, R4
        tag_pos = "R4 start-only rise"; tag_w = "R4 start-only width";
        send_byte(8'hFF);
        expect_drained("R4 only start pulse");
        send_byte(8'hF0);
        expect_drained("R4 low nibble only");

        // TXD rises mid-bit, R7
        tag_pos = "R7 frame rise"; tag_w = "R7 frame width";
        wait_tick(t0);
        exp_rise_q.push_back(t0 + 8); exp_w_q.push_back(pulse_len());
        #1 txd_ser = 1'b0;
        for (int k = 0; k < 5; k++) wait_tick(t);
        #1 txd_ser = 1'b1;
        idle_ticks(40);
        expect_drained("R7 one pulse, no chain");
        wait_tick(t0);
        exp_rise_q.push_back(t0 + 8);  exp_w_q.push_back(pulse_len());
        exp_rise_q.push_back(t0 + 24); exp_w_q.push_back(pulse_len());
        #1 txd_ser = 1'b0;
        for (int k = 0; k < 5; k++) wait_tick(t);
        #1 txd_ser = 1'b1;
        for (int k = 0; k < 8; k++) wait_tick(t);
        #1 txd_ser = 1'b0;
        for (int k = 0; k < 19; k++) wait_tick(t);
        #1 txd_ser = 1'b1;
        idle_ticks(40);
        expect_drained("R7 boundary decides chain");

        // fixed-width mode, R5
        fixed_mode = 1'b1;
        div = 2;
        idle_ticks(4);
        tag_pos = "R5 shot rise div2"; tag_w = "R5 shot width div2";
        send_byte(8'h55);
        expect_drained("R5 div2 pulses seen");
        div = 8;
        idle_ticks(4);
        tag_pos = "R5 shot rise div8"; tag_w = "R5 shot width div8";
        send_byte(8'h0F);
        expect_drained("R5 div8 pulses seen");

        // reset in mid pulse, R6
        fixed_mode = 1'b0;
        div = 4;
        idle_ticks(4);
        mon_en = 1'b0;
        wait_tick(t0);
        #1 txd_ser = 1'b0;
        for (int k = 0; k < 8; k++) wait_tick(t);
        @(negedge clk);
        check(ir_out == 1'b1, "R2 high before reset", ir_out, 1);
        #1 rst_n = 1'b0;
        txd_ser = 1'b1;
        #1 check(ir_out == 1'b0, "R6 drop on reset", ir_out, 0);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;
        idle_ticks(40);
        check(ir_out == 1'b0, "R6 idle after mid-pulse reset", ir_out, 0);
        expect_drained("R6 no pulse after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule